// File: doc/BRIEF.md
# Colour and Luma Histogram Collector with Area Masking

This block gathers four histograms over one video frame: red, green, blue and luminance. Each pixel arrives as four normalised samples with a valid strobe and a flag that says whether the pixel lies inside the programmed statistics window. A pixel inside the window adds one to the bin chosen by the top bits of each sample. A pixel outside the window adds one to bin 0 of all four histograms. This keeps the datapath free of any per-pixel window decision beyond a mux on the bin index.

When the frame end marker arrives, a sequential pass walks every red bin and totals them. It then compares that total against the pixel count the window should hold: grid width times grid height times the square of the cell edge, which is given as a power of two in quads. If the total is short of that figure, the result is marked unusable and left as it is. Otherwise the surplus, which is the red total minus the window count, is taken off bin 0 of all four histograms. A done flag then rises, and a read port returns any bin of any histogram one cycle after a request.

Top module: `rgbyh_hist`

## Requirements
- R1: For a valid pixel inside the window during collection, each histogram c (red, green, blue, luma) increments the bin whose index is the top BIN_BITS bits of that channel's sample.
- R2: A valid pixel outside the window increments bin 0 of all four histograms, whatever its samples are.
- R3: A bin that holds 2^COUNT_W-1 stays at that value when incremented again.
- R4: A frame start pulse clears every bin of all four histograms and drops the done and valid flags. Collection begins on the following cycle.
- R5: Pixels are counted only between frame start and frame end. A pixel with its valid strobe low is never counted. Pixels presented after the frame end leave the bins unchanged.
- R6: After frame end, if the red total is at least grid_w*grid_h*2^(2*cell_log2), the valid flag is set with done. Bin 0 of each histogram is then reduced by (red total minus that count), floored at zero.
- R7: If the red total is below that count, valid stays low and no bin is altered.
- R8: Done rises no sooner than 2^BIN_BITS cycles after the frame end pulse, once the pass over the red bins has finished.
- R9: With rd_en high, rd_data on the next cycle holds the bin selected by rd_bin in the histogram selected by rd_chan (0 red, 1 green, 2 blue, 3 luma). While done is low, rd_data reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_start | input | 1 | Start of frame pulse; clears the bins |
| frame_end | input | 1 | End of frame pulse; starts the correction pass |
| pix_valid | input | 1 | Pixel strobe |
| pix_in_area | input | 1 | Pixel lies inside the statistics window |
| pix_r | input | SAMPLE_W | Red sample |
| pix_g | input | SAMPLE_W | Green sample |
| pix_b | input | SAMPLE_W | Blue sample |
| pix_y | input | SAMPLE_W | Luma sample |
| grid_w | input | GRID_W | Window width in grid cells |
| grid_h | input | GRID_W | Window height in grid cells |
| cell_log2 | input | CELL_LOG2_W | log2 of the cell edge in quads |
| rd_en | input | 1 | Read request |
| rd_chan | input | 2 | Histogram select: 0 red, 1 green, 2 blue, 3 luma |
| rd_bin | input | BIN_BITS | Bin select |
| rd_data | output | COUNT_W | Bin count, one cycle after rd_en |
| hist_done | output | 1 | Correction pass finished; reads enabled |
| hist_valid | output | 1 | Red total reached the window count |

## Verification
The bench builds the block with 6-bit samples, 16 bins per histogram and 6-bit counts. With these values a single bin saturates after 63 hits, and the whole red scan takes only 16 cycles. Every bin of all four histograms can then be read back and compared after each frame. A 4-bit grid with a 2-bit cell exponent lets one frame reach the valid case with a small surplus. Another frame then falls short of a window count in the thousands, which exercises the unusable case without long streams.

// File: rtl/rgbyh_pkg.sv
package rgbyh_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_COLLECT,
    ST_SCAN,
    ST_FIX,
    ST_DONE
  } hist_state_e;

  localparam int NUM_CH = 4;
endpackage

// File: rtl/rgbyh_bank.sv
module rgbyh_bank #(
  parameter int BIN_BITS = 8,
  parameter int COUNT_W  = 24
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clr,
  input  logic                inc_en,
  input  logic [BIN_BITS-1:0] inc_idx,
  input  logic                fix_en,
  input  logic [COUNT_W-1:0]  fix_amt,
  input  logic [BIN_BITS-1:0] rd_idx,
  output logic [COUNT_W-1:0]  rd_data
);
  localparam int NBINS = 1 << BIN_BITS;
  localparam logic [COUNT_W-1:0] CNT_MAX = '1;

  logic [COUNT_W-1:0] bins_q  [NBINS];
  logic [COUNT_W-1:0] bins_nx [NBINS];

  // Next-state: clear wins, then increment (saturating) or bin-0 correction.
  always_comb begin
    for (int i = 0; i < NBINS; i++) bins_nx[i] = bins_q[i];
    if (clr) begin
      for (int i = 0; i < NBINS; i++) bins_nx[i] = '0;
    end else begin
      if (inc_en && (bins_q[inc_idx] != CNT_MAX))
        bins_nx[inc_idx] = bins_q[inc_idx] + 1'b1;
      if (fix_en)
        bins_nx[0] = (bins_q[0] > fix_amt) ? (bins_q[0] - fix_amt) : '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NBINS; i++) bins_q[i] <= '0;
    end else begin
      for (int i = 0; i < NBINS; i++) bins_q[i] <= bins_nx[i];
    end
  end

  assign rd_data = bins_q[rd_idx];

  assert_no_overflow_R3 : assert property (@(posedge clk) disable iff (!rst_n)
    (inc_en && !clr && !fix_en && bins_q[inc_idx] == CNT_MAX)
      |=> (bins_q[$past(inc_idx)] == CNT_MAX));

  assert_clear_bin0_R4 : assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (bins_q[0] == '0));
endmodule

// File: rtl/rgbyh_ctrl.sv
module rgbyh_ctrl
  import rgbyh_pkg::*;
#(
  parameter int BIN_BITS    = 8,
  parameter int COUNT_W     = 24,
  parameter int GRID_W      = 8,
  parameter int CELL_LOG2_W = 3
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   frame_start,
  input  logic                   frame_end,
  input  logic [GRID_W-1:0]      grid_w,
  input  logic [GRID_W-1:0]      grid_h,
  input  logic [CELL_LOG2_W-1:0] cell_log2,
  input  logic [COUNT_W-1:0]     scan_data,
  output logic                   collecting,
  output logic [BIN_BITS-1:0]    scan_idx,
  output logic                   clr,
  output logic                   fix_en,
  output logic [COUNT_W-1:0]     fix_amt,
  output logic                   done,
  output logic                   valid
);
  localparam int SUM_W  = COUNT_W + BIN_BITS;
  localparam int MAX_SH = 2 * ((1 << CELL_LOG2_W) - 1);
  localparam int EXP_W  = 2 * GRID_W + MAX_SH;
  localparam int CMP_W  = (SUM_W > EXP_W) ? SUM_W : EXP_W;
  localparam logic [BIN_BITS-1:0] LAST_BIN = '1;
  localparam logic [COUNT_W-1:0]  CNT_MAX  = '1;

  hist_state_e         state_q, state_nx;
  logic [BIN_BITS-1:0] idx_q, idx_nx;
  logic [CMP_W-1:0]    sum_q, sum_nx;
  logic [CMP_W-1:0]    exp_q, exp_nx;
  logic                valid_q, valid_nx;
  logic [CMP_W-1:0]    exp_calc;
  logic [CMP_W-1:0]    surplus;

  assign exp_calc = (CMP_W'(grid_w) * CMP_W'(grid_h)) << {cell_log2, 1'b0};
  assign surplus  = sum_q - exp_q;

  always_comb begin
    state_nx = state_q;
    idx_nx   = idx_q;
    sum_nx   = sum_q;
    exp_nx   = exp_q;
    valid_nx = valid_q;
    clr      = 1'b0;
    fix_en   = 1'b0;
    fix_amt  = '0;
    if (frame_start) begin
      state_nx = ST_COLLECT;
      clr      = 1'b1;
      valid_nx = 1'b0;
    end else begin
      case (state_q)
        ST_COLLECT: if (frame_end) begin
          state_nx = ST_SCAN;
          idx_nx   = '0;
          sum_nx   = '0;
          exp_nx   = exp_calc;
        end
        ST_SCAN: begin
          sum_nx = sum_q + CMP_W'(scan_data);
          idx_nx = idx_q + 1'b1;
          if (idx_q == LAST_BIN) state_nx = ST_FIX;
        end
        ST_FIX: begin
          state_nx = ST_DONE;
          if (sum_q >= exp_q) begin
            valid_nx = 1'b1;
            fix_en   = 1'b1;
            fix_amt  = (surplus > CMP_W'(CNT_MAX)) ? CNT_MAX : surplus[COUNT_W-1:0];
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      sum_q   <= '0;
      exp_q   <= '0;
      valid_q <= 1'b0;
    end else begin
      state_q <= state_nx;
      valid_q <= valid_nx;
      if (state_q == ST_SCAN || state_nx == ST_SCAN) begin
        idx_q <= idx_nx;
        sum_q <= sum_nx;
      end
      if (state_q == ST_COLLECT) exp_q <= exp_nx;
    end
  end

  assign collecting = (state_q == ST_COLLECT);
  assign scan_idx   = idx_q;
  assign done       = (state_q == ST_DONE);
  assign valid      = valid_q;

  assert_start_drops_done_R4 : assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> (!done && !valid));

  assert_valid_with_done_R6 : assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> done);

  assert_no_early_done_R8 : assert property (@(posedge clk) disable iff (!rst_n)
    (collecting && frame_end && !frame_start) |=> !done);
endmodule

// File: rtl/rgbyh_hist.sv
module rgbyh_hist
  import rgbyh_pkg::*;
#(
  parameter int SAMPLE_W    = 13,
  parameter int BIN_BITS    = 8,
  parameter int COUNT_W     = 24,
  parameter int GRID_W      = 8,
  parameter int CELL_LOG2_W = 3
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   frame_start,
  input  logic                   frame_end,
  input  logic                   pix_valid,
  input  logic                   pix_in_area,
  input  logic [SAMPLE_W-1:0]    pix_r,
  input  logic [SAMPLE_W-1:0]    pix_g,
  input  logic [SAMPLE_W-1:0]    pix_b,
  input  logic [SAMPLE_W-1:0]    pix_y,
  input  logic [GRID_W-1:0]      grid_w,
  input  logic [GRID_W-1:0]      grid_h,
  input  logic [CELL_LOG2_W-1:0] cell_log2,
  input  logic                   rd_en,
  input  logic [1:0]             rd_chan,
  input  logic [BIN_BITS-1:0]    rd_bin,
  output logic [COUNT_W-1:0]     rd_data,
  output logic                   hist_done,
  output logic                   hist_valid
);
  logic [NUM_CH-1:0][SAMPLE_W-1:0] samp;
  logic [NUM_CH-1:0][COUNT_W-1:0]  bank_data;
  logic                collecting, clr, fix_en, inc_en;
  logic [BIN_BITS-1:0] scan_idx, port_idx;
  logic [COUNT_W-1:0]  fix_amt;
  logic [COUNT_W-1:0]  rd_data_q, rd_data_nx;

  assign samp     = {pix_y, pix_b, pix_g, pix_r};
  assign inc_en   = collecting && pix_valid;
  assign port_idx = hist_done ? rd_bin : scan_idx;

  rgbyh_ctrl #(
    .BIN_BITS(BIN_BITS), .COUNT_W(COUNT_W),
    .GRID_W(GRID_W), .CELL_LOG2_W(CELL_LOG2_W)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .frame_start(frame_start), .frame_end(frame_end),
    .grid_w(grid_w), .grid_h(grid_h), .cell_log2(cell_log2),
    .scan_data(bank_data[0]),
    .collecting(collecting), .scan_idx(scan_idx), .clr(clr),
    .fix_en(fix_en), .fix_amt(fix_amt),
    .done(hist_done), .valid(hist_valid)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_bank
    logic [BIN_BITS-1:0] bin_sel;
    assign bin_sel = pix_in_area ? samp[c][SAMPLE_W-1 -: BIN_BITS] : '0;

    rgbyh_bank #(.BIN_BITS(BIN_BITS), .COUNT_W(COUNT_W)) u_bank (
      .clk(clk), .rst_n(rst_n), .clr(clr),
      .inc_en(inc_en), .inc_idx(bin_sel),
      .fix_en(fix_en), .fix_amt(fix_amt),
      .rd_idx(port_idx), .rd_data(bank_data[c])
    );
  end

  always_comb begin
    rd_data_nx = '0;
    if (rd_en && hist_done) rd_data_nx = bank_data[rd_chan];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_data_q <= '0;
    else        rd_data_q <= rd_data_nx;
  end

  assign rd_data = rd_data_q;

  assert_read_blocked_R9 : assert property (@(posedge clk) disable iff (!rst_n)
    !hist_done |=> (rd_data == '0));
endmodule

// File: tb/rgbyh_hist_tb.sv
`timescale 1ns/1ps
module rgbyh_hist_tb;
  localparam int SW = 6, BB = 4, CW = 6, GW = 4, CLW = 2;
  localparam int NB = 1 << BB;
  localparam int CMAX = (1 << CW) - 1;

  logic clk, rst_n;
  logic frame_start, frame_end, pix_valid, pix_in_area;
  logic [SW-1:0] pix_r, pix_g, pix_b, pix_y;
  logic [GW-1:0] grid_w, grid_h;
  logic [CLW-1:0] cell_log2;
  logic rd_en;
  logic [1:0] rd_chan;
  logic [BB-1:0] rd_bin;
  logic [CW-1:0] rd_data;
  logic hist_done, hist_valid;

  int n_checks = 0, n_fail = 0;
  int mdl [4][NB];
  bit collecting = 0;
  bit exp_valid;
  int exp_q[$];
  string tag_q[$];

  rgbyh_hist #(.SAMPLE_W(SW), .BIN_BITS(BB), .COUNT_W(CW), .GRID_W(GW), .CELL_LOG2_W(CLW)) u_dut (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .frame_end(frame_end),
    .pix_valid(pix_valid), .pix_in_area(pix_in_area),
    .pix_r(pix_r), .pix_g(pix_g), .pix_b(pix_b), .pix_y(pix_y),
    .grid_w(grid_w), .grid_h(grid_h), .cell_log2(cell_log2),
    .rd_en(rd_en), .rd_chan(rd_chan), .rd_bin(rd_bin), .rd_data(rd_data),
    .hist_done(hist_done), .hist_valid(hist_valid));

  initial clk = 0;
  always #2 clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int expv);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  // Monitor: compares each read response against the scoreboard queue.
  initial begin
    forever begin
      @(posedge clk);
      if (rd_en) begin
        int e;
        string t;
        @(negedge clk);
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(int'(rd_data) == e, t, int'(rd_data), e);
      end
    end
  end

  task automatic read_bin(input int ch, input int b, input int expv, input string t);
    @(negedge clk);
    rd_en = 1; rd_chan = 2'(ch); rd_bin = BB'(b);
    exp_q.push_back(expv); tag_q.push_back(t);
    @(negedge clk);
    rd_en = 0;
  endtask

  task automatic read_all(input string t);
    for (int ch = 0; ch < 4; ch++)
      for (int b = 0; b < NB; b++) read_bin(ch, b, mdl[ch][b], t);
  endtask

  task automatic pix(input bit v, input bit a, input int r, input int g, input int b, input int y);
    int s[4];
    @(negedge clk);
    pix_valid = v; pix_in_area = a;
    pix_r = SW'(r); pix_g = SW'(g); pix_b = SW'(b); pix_y = SW'(y);
    s[0] = r; s[1] = g; s[2] = b; s[3] = y;
    if (collecting && v)
      for (int c = 0; c < 4; c++) begin
        int idx;
        idx = a ? (s[c] >> (SW - BB)) : 0;
        if (mdl[c][idx] < CMAX) mdl[c][idx]++;
      end
    @(negedge clk);
    pix_valid = 0;
  endtask

  task automatic start_frame(input int w, input int h, input int cl);
    @(negedge clk);
    grid_w = GW'(w); grid_h = GW'(h); cell_log2 = CLW'(cl);
    frame_start = 1;
    @(negedge clk);
    frame_start = 0;
    for (int c = 0; c < 4; c++) for (int b = 0; b < NB; b++) mdl[c][b] = 0;
    collecting = 1;
    check(!hist_done && !hist_valid, "R4 flags low after frame start", int'(hist_done), 0);
  endtask

  task automatic end_frame();
    int sum_r, expc, cyc;
    @(negedge clk);
    frame_end = 1;
    collecting = 0;
    @(negedge clk);
    frame_end = 0;
    sum_r = 0;
    for (int b = 0; b < NB; b++) sum_r += mdl[0][b];
    expc = (int'(grid_w) * int'(grid_h)) << (2 * int'(cell_log2));
    exp_valid = (sum_r >= expc);
    if (exp_valid)
      for (int c = 0; c < 4; c++)
        mdl[c][0] = (mdl[c][0] > sum_r - expc) ? mdl[c][0] - (sum_r - expc) : 0;
    cyc = 1;
    while (!hist_done && cyc < 1000) begin
      @(negedge clk);
      cyc++;
    end
    check(cyc >= NB, "R8 done not before full scan", cyc, NB);
    check(hist_valid == exp_valid, exp_valid ? "R6 valid set" : "R7 valid low",
          int'(hist_valid), int'(exp_valid));
  endtask

  initial begin
    #400000;
    n_checks++; n_fail++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    rst_n = 0; frame_start = 0; frame_end = 0; pix_valid = 0; pix_in_area = 0;
    pix_r = 0; pix_g = 0; pix_b = 0; pix_y = 0; grid_w = 0; grid_h = 0; cell_log2 = 0;
    rd_en = 0; rd_chan = 0; rd_bin = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    check(!hist_done && !hist_valid && rd_data == 0, "R9 reset state", int'(hist_done), 0);
    read_bin(0, 0, 0, "R9 read before done is zero");

    // Frame A: window 2x1 cells of 2x2 quads = 8; 8 in-area, 5 outside, 3 invalid strobes.
    start_frame(2, 1, 1);
    for (int i = 0; i < 8; i++) pix(1, 1, i * 8, 63 - i * 4, i * 5, 20 + i);   // R1
    for (int i = 0; i < 5; i++) pix(1, 0, 60, 50 - i, 40, 33);                // R2
    for (int i = 0; i < 3; i++) pix(0, 1, 12, 12, 12, 12);                    // R5
    read_bin(0, 0, 0, "R9 read blocked while collecting");
    end_frame();
    read_all("R6 R1 R2 bins after correction");

    // Pixels after frame end must not change any bin.
    for (int i = 0; i < 4; i++) pix(1, 1, 44, 44, 44, 44);
    read_bin(0, 11, mdl[0][11], "R5 late pixel ignored red");
    read_bin(3, 11, mdl[3][11], "R5 late pixel ignored luma");
    read_bin(1, 0, mdl[1][0], "R5 late pixel ignored bin0");

    // Frame B: window count far above the red total; no correction.
    start_frame(15, 15, 3);
    for (int i = 0; i < 6; i++) pix(1, 1, i * 10, i * 9, i * 7, i * 11);
    for (int i = 0; i < 4; i++) pix(1, 0, 63, 63, 63, 63);
    end_frame();
    read_all("R7 R4 bins unchanged and cleared");

    // Frame C: saturation of one bin.
    start_frame(10, 7, 0);
    for (int i = 0; i < 70; i++) pix(1, 1, 61, 62, 60, 63);
    end_frame();
    read_bin(0, NB - 1, CMAX, "R3 red bin saturates");
    read_bin(3, NB - 1, CMAX, "R3 luma bin saturates");
    read_bin(2, 0, 0, "R3 other bins empty");

    repeat (4) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule